// File: doc/BRIEF.md
# Mode-Filtered Event Counter with Sticky Overflow Flag

This block holds one hardware performance counter and its event-control register. Each clock cycle, a single-bit event pulse may add one to the counter. The pulse is counted only when the current privilege mode of the hart has not been excluded by that mode's inhibit bit in the control register. The counter is unsigned and has a width set by a parameter. When a hardware increment carries it past its all-ones value, it wraps to zero and keeps counting.

A wrap sets a sticky overflow flag. If the flag was clear before the wrap, the block also raises a one-cycle overflow interrupt request. If the flag was already set, no request is raised, so the flag also serves as the interrupt disable. Software reads the counter and the control register through two read buses and writes them through two write strobes that share one data bus. Loads from software never count as an overflow.

The flag is tracked by a two-state machine. `OF_ARMED` means the flag is clear and an interrupt can be raised. `OF_LATCHED` means the flag is set. The machine has these transitions:
- ARMED→LATCHED on a hardware wrap (the request pulses).
- ARMED→LATCHED on a control write with the flag bit set (no request).
- LATCHED→ARMED on a control write with the flag bit clear.
- LATCHED→LATCHED on a wrap or when idle.

Top module: `perf_counter_filt`

## Requirements
- R1: After reset the counter, the control register, `of_flag` and `irq_req` are all zero.
- R2: An event pulse in a cycle whose privilege mode is not inhibited adds exactly one to the counter at the next clock edge. With all inhibit bits clear, every mode counts. With no pulse, the counter holds.
- R3: Control bits 62, 61, 60, 59 and 58 inhibit counting in the M, S/HS, U, VS and VU modes respectively. An event pulse in an inhibited mode leaves the counter unchanged.
- R4: `priv_mode` encodes U=0, S/HS=1, M=3, VU=4, VS=5. Events under the unassigned codes 2, 6 and 7 are never counted.
- R5: Control bits 57..0 read as zero. The inhibit bit of a mode not implemented (parameters `HAS_S`, `HAS_U`, `HAS_VIRT`) reads as zero whatever is written, so events in that mode are never inhibited.
- R6: A hardware increment from all ones gives zero, and later events keep counting from zero.
- R7: A wrap sets `of_flag`, which is also control bit 63. The flag stays set until a control write, which loads bit 63 of `wdata`.
- R8: A wrap while the flag is clear raises `irq_req` for exactly one cycle, the same cycle in which `of_flag` first reads 1. A wrap while the flag is set raises no request.
- R9: A counter write loads `wdata` and takes priority over an event in the same cycle. A counter write never sets the flag and never raises a request, even when it loads or replaces all ones.
- R10: When a control write falls in the same cycle as a wrap, the counter still wraps to zero, the written flag value takes effect, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_mode | input | 3 | Current privilege mode (encoding in R4) |
| event_pulse | input | 1 | One event to count this cycle |
| cnt_we | input | 1 | Software write strobe for the counter |
| ctrl_we | input | 1 | Software write strobe for the control register |
| wdata | input | 64 | Software write data for either register |
| cnt_rdata | output | CNT_W | Current counter value |
| ctrl_rdata | output | 64 | Control register: flag at bit 63, inhibits at 62..58 |
| of_flag | output | 1 | Sticky overflow flag |
| irq_req | output | 1 | One-cycle overflow interrupt request |

## Verification
A hardware wrap can land in the same cycle as a software write to either register. That cycle decides whether the counter wraps, what the flag becomes, and whether a request is raised. The bench provokes this by loading all ones into the counter and, in the next cycle, driving an event pulse together with a counter write and then together with control writes of each flag value. A reference model applies the priorities stated in R9 and R10, and the bench compares the counter, the control readback, the flag and the request against it one edge later.

// File: rtl/pc_pkg.sv
package pc_pkg;

    localparam int CTRL_W   = 64;
    localparam int OF_POS   = 63;
    localparam int INH_N    = 5;
    localparam int INH_LSB  = 58;

    // inhibit vector index per mode (vector bit i sits at control bit INH_LSB+i)
    localparam int IX_VU = 0;
    localparam int IX_VS = 1;
    localparam int IX_U  = 2;
    localparam int IX_S  = 3;
    localparam int IX_M  = 4;

    typedef enum logic [2:0] {
        PRIV_U  = 3'd0,
        PRIV_S  = 3'd1,
        PRIV_M  = 3'd3,
        PRIV_VU = 3'd4,
        PRIV_VS = 3'd5
    } priv_e;

    typedef enum logic {
        OF_ARMED   = 1'b0,
        OF_LATCHED = 1'b1
    } of_state_e;

endpackage

// File: rtl/pc_mode_gate.sv
module pc_mode_gate
    import pc_pkg::*;
(
    input  logic [2:0]       mode,
    input  logic [INH_N-1:0] inh,
    output logic             count_ok
);

    priv_e mode_e;
    assign mode_e = priv_e'(mode);

    always_comb begin
        unique case (mode_e)
            PRIV_M:  count_ok = !inh[IX_M];
            PRIV_S:  count_ok = !inh[IX_S];
            PRIV_U:  count_ok = !inh[IX_U];
            PRIV_VS: count_ok = !inh[IX_VS];
            PRIV_VU: count_ok = !inh[IX_VU];
            default: count_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/pc_counter.sv
module pc_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // only a hardware increment that is not overridden by a load can wrap
    assign wrap = inc && !load && (&cnt);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (inc)
            cnt <= cnt + ONE;
    end

endmodule

// File: rtl/pc_of_fsm.sv
module pc_of_fsm
    import pc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_wrap,
    input  logic sw_we,
    input  logic sw_of,
    output logic of_flag,
    output logic irq_req
);

    of_state_e state_q, state_d;
    logic      irq_q, irq_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OF_ARMED;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        irq_d   = 1'b0;
        unique case (state_q)
            OF_ARMED: begin
                if (sw_we) begin
                    state_d = sw_of ? OF_LATCHED : OF_ARMED;
                end else if (hw_wrap) begin
                    state_d = OF_LATCHED;
                    irq_d   = 1'b1;
                end
            end
            OF_LATCHED: begin
                if (sw_we && !sw_of)
                    state_d = OF_ARMED;
            end
            default: state_d = OF_ARMED;
        endcase
    end

    assign of_flag = (state_q == OF_LATCHED);
    assign irq_req = irq_q;

endmodule

// File: rtl/perf_counter_filt.sv
module perf_counter_filt
    import pc_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter bit HAS_S    = 1'b1,
    parameter bit HAS_U    = 1'b1,
    parameter bit HAS_VIRT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        priv_mode,
    input  logic              event_pulse,
    input  logic              cnt_we,
    input  logic              ctrl_we,
    input  logic [63:0]       wdata,
    output logic [CNT_W-1:0]  cnt_rdata,
    output logic [63:0]       ctrl_rdata,
    output logic              of_flag,
    output logic              irq_req
);

    localparam logic [INH_N-1:0] IMPL_MASK = {1'b1, HAS_S, HAS_U, HAS_VIRT, HAS_VIRT};

    logic [INH_N-1:0] inh_q;
    logic             count_ok;
    logic             hw_wrap;

    // inhibit storage; unimplemented modes keep a constant zero bit
    for (genvar i = 0; i < INH_N; i++) begin : g_inh
        if (IMPL_MASK[i]) begin : g_impl
            always_ff @(posedge clk) begin
                if (!rst_n)
                    inh_q[i] <= 1'b0;
                else if (ctrl_we)
                    inh_q[i] <= wdata[INH_LSB+i];
            end
        end else begin : g_ro0
            assign inh_q[i] = 1'b0;
        end
    end

    pc_mode_gate u_gate (
        .mode     (priv_mode),
        .inh      (inh_q),
        .count_ok (count_ok)
    );

    pc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_we),
        .load_val (wdata[CNT_W-1:0]),
        .inc      (event_pulse && count_ok),
        .cnt      (cnt_rdata),
        .wrap     (hw_wrap)
    );

    pc_of_fsm u_of (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_wrap (hw_wrap),
        .sw_we   (ctrl_we),
        .sw_of   (wdata[OF_POS]),
        .of_flag (of_flag),
        .irq_req (irq_req)
    );

    always_comb begin
        ctrl_rdata = '0;
        ctrl_rdata[OF_POS] = of_flag;
        ctrl_rdata[INH_LSB +: INH_N] = inh_q;
    end

endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       priv_mode,
    input logic             event_pulse,
    input logic             cnt_we,
    input logic             ctrl_we,
    input logic [CNT_W-1:0] cnt_rdata,
    input logic [63:0]      ctrl_rdata,
    input logic             of_flag,
    input logic             irq_req
);

    AST_IRQ_IMPLIES_OF: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> of_flag);                                                  // R8
    AST_IRQ_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !$past(of_flag));                                          // R8
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);                                                 // R8
    AST_NO_IRQ_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> !irq_req);                                                  // R9
    AST_NO_IRQ_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> !irq_req);                                                 // R10
    AST_OF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (of_flag && !ctrl_we) |=> of_flag);                                    // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!event_pulse && !cnt_we) |=> $stable(cnt_rdata));                     // R2
    AST_M_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_mode == 3'd3 && ctrl_rdata[62] && !cnt_we) |=> $stable(cnt_rdata)); // R3
    AST_BAD_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((priv_mode == 3'd2 || priv_mode >= 3'd6) && !cnt_we) |=> $stable(cnt_rdata)); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[57:0] == '0);                                               // R5

endmodule

bind perf_counter_filt pc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .priv_mode   (priv_mode),
    .event_pulse (event_pulse),
    .cnt_we      (cnt_we),
    .ctrl_we     (ctrl_we),
    .cnt_rdata   (cnt_rdata),
    .ctrl_rdata  (ctrl_rdata),
    .of_flag     (of_flag),
    .irq_req     (irq_req)
);

// File: tb/tb_perf_counter_filt.sv
`timescale 1ns/1ps
module tb_perf_counter_filt;

    localparam logic [2:0] MU = 3'd0, MS = 3'd1, MM = 3'd3, MVU = 3'd4, MVS = 3'd5;
    localparam logic [63:0] ONES = '1;

    typedef struct {
        logic [63:0] cnt;
        logic [63:0] ctrl;
        logic        irq;
        logic        of_;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  priv_mode = '0;
    logic        event_pulse = 1'b0, cnt_we = 1'b0, ctrl_we = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] cnt_rdata, ctrl_rdata;
    logic        of_flag, irq_req;

    logic        nv_ev = 1'b0, nv_cwe = 1'b0;
    logic [2:0]  nv_mode = '0;
    logic [63:0] nv_wdata = '0;
    logic [63:0] nv_cnt, nv_ctrl;
    logic        nv_of, nv_irq;

    int checks = 0;
    int failures = 0;
    exp_t q[$];

    // reference state
    logic [63:0] m_cnt = '0;
    logic [4:0]  m_inh = '0;
    logic        m_of = 1'b0;

    always #2 clk = ~clk;

    perf_counter_filt dut (
        .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .event_pulse(event_pulse),
        .cnt_we(cnt_we), .ctrl_we(ctrl_we), .wdata(wdata),
        .cnt_rdata(cnt_rdata), .ctrl_rdata(ctrl_rdata), .of_flag(of_flag), .irq_req(irq_req)
    );

    perf_counter_filt #(.HAS_U(1'b0), .HAS_VIRT(1'b0)) dut_nv (
        .clk(clk), .rst_n(rst_n), .priv_mode(nv_mode), .event_pulse(nv_ev),
        .cnt_we(1'b0), .ctrl_we(nv_cwe), .wdata(nv_wdata),
        .cnt_rdata(nv_cnt), .ctrl_rdata(nv_ctrl), .of_flag(nv_of), .irq_req(nv_irq)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic mode_counts(input logic [2:0] md, input logic [4:0] inh);
        case (md)
            MM:  return !inh[4];
            MS:  return !inh[3];
            MU:  return !inh[2];
            MVS: return !inh[1];
            MVU: return !inh[0];
            default: return 1'b0;
        endcase
    endfunction

    // driver: applies one cycle of stimulus and queues the expected outcome
    task automatic step(input logic ev, input logic [2:0] md, input logic cwe,
                        input logic twe, input logic [63:0] wd, input string req);
        exp_t e;
        logic ovf, irq;
        @(negedge clk);
        event_pulse = ev; priv_mode = md; cnt_we = cwe; ctrl_we = twe; wdata = wd;
        ovf = 1'b0; irq = 1'b0;
        if (cwe) m_cnt = wd;
        else if (ev && mode_counts(md, m_inh)) begin
            if (m_cnt == ONES) begin m_cnt = '0; ovf = 1'b1; end
            else m_cnt = m_cnt + 64'd1;
        end
        if (twe) begin m_of = wd[63]; m_inh = wd[62:58]; end
        else if (ovf && !m_of) begin m_of = 1'b1; irq = 1'b1; end
        @(posedge clk);
        #1;
        event_pulse = 1'b0; cnt_we = 1'b0; ctrl_we = 1'b0;
        e.cnt = m_cnt; e.ctrl = {m_of, m_inh, 58'd0}; e.irq = irq; e.of_ = m_of; e.req = req;
        q.push_back(e);
    endtask

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, "cnt",  cnt_rdata, e.cnt);
            chk(e.req, "ctrl", ctrl_rdata, e.ctrl);
            chk(e.req, "irq",  {63'd0, irq_req}, {63'd0, e.irq});
            chk(e.req, "of",   {63'd0, of_flag}, {63'd0, e.of_});
        end
    end

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "cnt", cnt_rdata, '0);
        chk("R1", "ctrl", ctrl_rdata, '0);
        chk("R1", "irq_of", {62'd0, irq_req, of_flag}, '0);
        rst_n = 1'b1;

        // R2 counting in every mode with no inhibit
        step(1, MM, 0, 0, '0, "R2");
        step(1, MS, 0, 0, '0, "R2");
        step(1, MU, 0, 0, '0, "R2");
        step(1, MVS, 0, 0, '0, "R2");
        step(1, MVU, 0, 0, '0, "R2");
        step(0, MM, 0, 0, '0, "R2");

        // R3 per-mode inhibit
        step(0, MM, 0, 1, 64'h4000_0000_0000_0000, "R3");
        step(1, MM, 0, 0, '0, "R3");
        step(1, MS, 0, 0, '0, "R3");
        step(0, MM, 0, 1, 64'h7C00_0000_0000_0000, "R3");
        step(1, MM, 0, 0, '0, "R3");
        step(1, MS, 0, 0, '0, "R3");
        step(1, MU, 0, 0, '0, "R3");
        step(1, MVS, 0, 0, '0, "R3");
        step(1, MVU, 0, 0, '0, "R3");
        step(0, MM, 0, 1, 64'h0400_0000_0000_0000, "R3");
        step(1, MVU, 0, 0, '0, "R3");
        step(1, MVS, 0, 0, '0, "R3");
        step(0, MM, 0, 1, '0, "R3");

        // R4 unassigned mode codes
        step(1, 3'd2, 0, 0, '0, "R4");
        step(1, 3'd6, 0, 0, '0, "R4");
        step(1, 3'd7, 0, 0, '0, "R4");

        // R6 R7 R8 wrap, sticky flag, single request
        step(0, MM, 1, 0, ONES - 64'd1, "R9");
        step(1, MM, 0, 0, '0, "R6");
        step(1, MM, 0, 0, '0, "R8");
        step(1, MS, 0, 0, '0, "R6");
        step(0, MS, 0, 0, '0, "R7");
        step(0, MM, 1, 0, ONES, "R9");
        step(1, MM, 0, 0, '0, "R8");
        step(0, MM, 0, 1, '0, "R7");

        // R9 counter write wins and never overflows
        step(0, MM, 1, 0, ONES, "R9");
        step(1, MM, 1, 0, ONES, "R9");
        step(1, MM, 1, 0, 64'd5, "R9");
        step(0, MM, 1, 0, ONES, "R9");
        step(0, MM, 1, 0, '0, "R9");

        // R10 control write coincides with wrap
        step(0, MM, 1, 0, ONES, "R10");
        step(1, MM, 0, 1, '0, "R10");
        step(0, MM, 1, 0, ONES, "R10");
        step(1, MM, 0, 1, 64'h8000_0000_0000_0000, "R10");
        step(0, MM, 0, 1, '0, "R10");

        // R5 reserved and unimplemented bits
        step(0, MM, 0, 1, ONES, "R5");
        step(0, MM, 0, 1, '0, "R5");
        @(negedge clk);
        nv_cwe = 1'b1; nv_wdata = ONES;
        @(posedge clk); #1; nv_cwe = 1'b0;
        @(negedge clk);
        chk("R5", "nv_ctrl", nv_ctrl, 64'hE000_0000_0000_0000);
        nv_ev = 1'b1; nv_mode = MVU;
        @(posedge clk); #1; nv_ev = 1'b0;
        @(negedge clk);
        chk("R5", "nv_cnt", nv_cnt, 64'd1);
        nv_ev = 1'b1; nv_mode = MM;
        @(posedge clk); #1; nv_ev = 1'b0;
        @(negedge clk);
        chk("R5", "nv_cnt_m", nv_cnt, 64'd1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule